// File: doc/BRIEF.md
# Adaptive Approximate Unsigned Divider

This block divides a 2N-bit unsigned dividend by an N-bit unsigned divisor and returns an approximate 2N-bit quotient. Only a few significant bits of each operand are used. The block finds the leading one of each operand and keeps a short window that starts at that bit: 2K bits of the dividend and K bits of the divisor. Those two windows go to a small exact divider. A shifter then moves the narrow quotient back to the full scale, using the distance between the two leading ones.

When the shifter moves the result left, the low bits it vacates would otherwise stay zero. A row of OR gates fills them with ones if any dividend bit below the window was set. This corrects part of the truncation error. A zero divisor raises a divide-by-zero flag and forces an all-ones quotient.

The block has one register stage. An operand pair that is accepted with `in_valid` produces its result on the next clock edge, together with `out_valid`. The window size K sets both the size of the core and the accuracy. For the default N = 8, K = 3, the core is an 8-bit by 4-bit exact divider.

Top module: `apx_div`

## Requirements
- R1: An operand pair sampled with `in_valid` high on a rising edge produces its quotient and flag after that edge. `out_valid` is high for the cycle after each cycle in which `in_valid` was high, and low otherwise.
- R2: While `rst_n` is low, `out_valid`, `quotient` and `div_by_zero` are all driven to zero.
- R3: For nonzero operands, let pa be the leading-one index of the dividend and pb that of the divisor. Let WA be the 2K bits of the dividend starting at bit pa and going down, and WB be the K bits of the divisor starting at bit pb. Let c = floor(WA / WB) and s = pa - pb - K. Dividend and divisor bits below their windows are dropped. For example, 100/7 gives 14.
- R4: When fewer bits remain below a leading one than the window holds, the missing low window positions are zero. For example, 5/3 uses WA = 101000b and WB = 110b, which gives quotient 1.
- R5: When s >= 0 the quotient is c shifted left by s. When s > 0 and any dividend bit below its window is 1, the low s bits of the quotient are forced to 1. For example, 1000/3 gives 351 and 65535/1 gives 65535. With no dropped ones the low bits stay 0, so 32768/1 gives 32768.
- R6: When s < 0 the quotient is c shifted right by -s, with the shifted-out bits discarded.
- R7: A zero divisor sets `div_by_zero` to 1 and the quotient to all ones. This takes priority over a zero dividend, so 0/0 gives all ones with the flag set. Any nonzero divisor clears the flag.
- R8: A zero dividend with a nonzero divisor gives quotient 0.
- R9: For a nonzero divisor, with t = floor(dividend / divisor), the quotient q satisfies 2q + 2 >= t and q <= 2t + 1. No saturation is ever needed, because c < 2^(K+1) and s <= 2N-1-K.
- R10: A cycle with `in_valid` low leaves `quotient` and `div_by_zero` unchanged, whatever the operand inputs hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operand pair valid this cycle |
| dividend | input | 2N | Unsigned dividend |
| divisor | input | N | Unsigned divisor |
| out_valid | output | 1 | Result registers hold a new result |
| quotient | output | 2N | Approximate quotient |
| div_by_zero | output | 1 | Divisor of the result was zero |

## Verification
Two functions can claim the same result: the divide-by-zero override and the zero-dividend path. Both apply when the bench drives 0/0 in one cycle. The block must report all ones with the flag set. The second meeting point is the widest left shift combined with the OR fill: 65535/1 shifts by the maximum amount and also has dropped dividend ones, so the correction must fill all twelve vacated bits without corrupting the shifted core bits. Random operands are masked to random lengths, so short operands that take the zero-fill path and zero operands occur often. Each result is judged against a bench model of R3 to R8 and against the accuracy bound of R9.

// File: rtl/apx_div_pkg.sv
package apx_div_pkg;

   // Direction of the rescaling step applied to the core quotient.
   typedef enum logic [1:0] {
      SCALE_NONE = 2'd0,
      SCALE_UP   = 2'd1,
      SCALE_DOWN = 2'd2
   } scale_dir_e;

   // Signed width that holds the rescale distance for a dividend of dvd_w bits.
   function automatic int shift_bits(input int dvd_w, input int win_k);
      return $clog2(dvd_w + win_k + 1) + 1;
   endfunction

endpackage

// File: rtl/apx_lod.sv
module apx_lod #(
   parameter int W  = 16,
   localparam int PW = (W > 1) ? $clog2(W) : 1
) (
   input  logic [W-1:0]  vec,
   output logic [PW-1:0] pos,
   output logic          none
);

   if (W < 2) begin : g_bad_w
      $error("apx_lod: W must be at least 2");
   end

   // The highest set bit wins, because the scan runs upward and overwrites.
   always_comb begin
      pos = '0;
      for (int i = 0; i < W; i++) begin
         if (vec[i]) pos = PW'(i);
      end
   end

   assign none = ~|vec;

endmodule

// File: rtl/apx_window.sv
module apx_window #(
   parameter int W   = 16,
   parameter int WIN = 6,
   localparam int PW = $clog2(W)
) (
   input  logic [W-1:0]   vec,
   output logic [WIN-1:0] win,
   output logic [PW-1:0]  lead,
   output logic           none,
   output logic           lost
);

   localparam logic [PW-1:0] TOP = PW'(W - 1);

   if (WIN < 1 || WIN >= W) begin : g_bad_win
      $error("apx_window: WIN must be in 1..W-1");
   end

   logic [W-1:0] norm;

   apx_lod #(.W(W)) u_lod (
      .vec  (vec),
      .pos  (lead),
      .none (none)
   );

   // Moving the leading one to the top keeps every set bit, and zero-fills from below.
   assign norm = vec << (TOP - lead);
   assign win  = norm[W-1 -: WIN];
   assign lost = |norm[W-WIN-1:0];

endmodule

// File: rtl/apx_core.sv
module apx_core #(
   parameter int QW  = 4,
   localparam int DW = 2 * QW
) (
   input  logic [DW-1:0] dvd,
   input  logic [QW-1:0] dvs,
   output logic [DW-1:0] quo
);

   if (QW < 2) begin : g_bad_qw
      $error("apx_core: QW must be at least 2");
   end

   logic [QW-1:0] rem [0:DW];

   assign rem[0] = '0;

   // One restoring step per dividend bit, from the top bit down.
   for (genvar i = 0; i < DW; i++) begin : g_step
      logic [QW:0] trial;
      logic [QW:0] diff;
      logic        ge;
      assign trial = {rem[i], dvd[DW-1-i]};
      assign ge    = (trial >= {1'b0, dvs});
      assign diff  = trial - {1'b0, dvs};
      assign quo[DW-1-i] = ge;
      assign rem[i+1]    = ge ? diff[QW-1:0] : trial[QW-1:0];
   end

endmodule

// File: rtl/apx_scale.sv
module apx_scale
   import apx_div_pkg::*;
#(
   parameter int CW     = 8,
   parameter int OW     = 16,
   parameter int SHW    = 6,
   parameter bit OR_FIX = 1'b1
) (
   input  logic [CW-1:0]         cq,
   input  logic signed [SHW-1:0] shamt,
   input  logic                  lost,
   output logic [OW-1:0]         q
);

   if (CW > OW) begin : g_bad_cw
      $error("apx_scale: core quotient wider than result");
   end

   scale_dir_e     dir;
   logic [SHW-1:0] mag;
   logic [OW-1:0]  up_raw;
   logic [OW-1:0]  up_fix;
   logic [OW-1:0]  down;
   logic [OW-1:0]  fill;

   always_comb begin
      if (shamt[SHW-1]) begin
         dir = SCALE_DOWN;
         mag = -shamt;
      end else if (shamt == '0) begin
         dir = SCALE_NONE;
         mag = '0;
      end else begin
         dir = SCALE_UP;
         mag = shamt;
      end
   end

   assign up_raw = OW'(cq) << mag;
   assign down   = OW'(cq >> mag);
   assign fill   = (OW'(1) << mag) - OW'(1);

   if (OR_FIX) begin : g_or_fix
      assign up_fix = up_raw | (lost ? fill : '0);
   end else begin : g_plain
      assign up_fix = up_raw;
   end

   always_comb begin
      unique case (dir)
         SCALE_UP:   q = up_fix;
         SCALE_DOWN: q = down;
         default:    q = OW'(cq);
      endcase
   end

endmodule

// File: rtl/apx_div.sv
module apx_div
   import apx_div_pkg::*;
#(
   parameter int N      = 8,
   parameter int K      = 3,
   parameter bit OR_FIX = 1'b1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           in_valid,
   input  logic [2*N-1:0] dividend,
   input  logic [N-1:0]   divisor,
   output logic           out_valid,
   output logic [2*N-1:0] quotient,
   output logic           div_by_zero
);

   localparam int DW  = 2 * N;
   localparam int WA  = 2 * K;
   localparam int QW  = K + 1;
   localparam int CW  = 2 * QW;
   localparam int SHW = shift_bits(DW, K);
   localparam int PA  = $clog2(DW);
   localparam int PB  = $clog2(N);

   if (K < 2 || K >= N) begin : g_bad_k
      $error("apx_div: K must satisfy 2 <= K < N");
   end

   logic [WA-1:0]         win_a;
   logic [K-1:0]          win_b;
   logic [PA-1:0]         lead_a;
   logic [PB-1:0]         lead_b;
   logic                  zero_a;
   logic                  zero_b;
   logic                  lost_a;
   logic                  lost_b;
   logic [CW-1:0]         core_q;
   logic signed [SHW-1:0] shamt;
   logic [DW-1:0]         scaled;
   logic [DW-1:0]         result;

   apx_window #(.W(DW), .WIN(WA)) u_win_a (
      .vec  (dividend),
      .win  (win_a),
      .lead (lead_a),
      .none (zero_a),
      .lost (lost_a)
   );

   apx_window #(.W(N), .WIN(K)) u_win_b (
      .vec  (divisor),
      .win  (win_b),
      .lead (lead_b),
      .none (zero_b),
      .lost (lost_b)
   );

   // Both windows enter the core with zero headroom above them.
   apx_core #(.QW(QW)) u_core (
      .dvd ({2'b00, win_a}),
      .dvs ({1'b0, win_b}),
      .quo (core_q)
   );

   assign shamt = $signed(SHW'(lead_a)) - $signed(SHW'(lead_b)) - $signed(SHW'(K));

   apx_scale #(.CW(CW), .OW(DW), .SHW(SHW), .OR_FIX(OR_FIX)) u_scale (
      .cq    (core_q),
      .shamt (shamt),
      .lost  (lost_a),
      .q     (scaled)
   );

   always_comb begin
      if (zero_b)      result = '1;
      else if (zero_a) result = '0;
      else             result = scaled;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid   <= 1'b0;
         quotient    <= '0;
         div_by_zero <= 1'b0;
      end else begin
         out_valid <= in_valid;
         if (in_valid) begin
            quotient    <= result;
            div_by_zero <= zero_b;
         end
      end
   end

   logic unused_lost_b;
   assign unused_lost_b = lost_b;

endmodule

// File: rtl/apx_div_chk.sv
module apx_div_chk #(
   parameter int N = 8
) (
   input logic           clk,
   input logic           rst_n,
   input logic           in_valid,
   input logic [2*N-1:0] dividend,
   input logic [N-1:0]   divisor,
   input logic           out_valid,
   input logic [2*N-1:0] quotient,
   input logic           div_by_zero
);

   AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);                                             // R1
   AST_VALID_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);                                           // R1
   AST_DBZ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> (div_by_zero == ($past(divisor) == '0)));               // R7
   AST_DBZ_ONES: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && div_by_zero) |-> (quotient == '1));                    // R7
   AST_ZERO_DIVIDEND: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && dividend == '0 && divisor != '0) |=> (quotient == '0)); // R8
   AST_UPPER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && divisor != '0) |=>
         (48'(quotient) * 48'($past(divisor)) <=
          48'($past(dividend)) * 48'd2 + 48'($past(divisor))));            // R9
   AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(quotient) && $stable(div_by_zero)));          // R10

endmodule

bind apx_div apx_div_chk #(.N(N)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .in_valid    (in_valid),
   .dividend    (dividend),
   .divisor     (divisor),
   .out_valid   (out_valid),
   .quotient    (quotient),
   .div_by_zero (div_by_zero)
);

// File: tb/apx_div_tb.sv
`timescale 1ns/1ps
module apx_div_tb_top;

   localparam int N  = 8;
   localparam int K  = 3;
   localparam int DW = 2 * N;
   localparam longint unsigned QMAX = (64'd1 << DW) - 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic [DW-1:0] dividend = '0;
   logic [N-1:0]  divisor = '0;
   logic          out_valid;
   logic [DW-1:0] quotient;
   logic          div_by_zero;

   int n_checks = 0;
   int n_fail   = 0;
   int cycles   = 0;
   bit finished = 0;

   always #10 clk = ~clk;

   apx_div #(.N(N), .K(K)) dut_i (
      .clk (clk), .rst_n (rst_n), .in_valid (in_valid),
      .dividend (dividend), .divisor (divisor),
      .out_valid (out_valid), .quotient (quotient), .div_by_zero (div_by_zero)
   );

   task automatic check(input bit ok, input string req, input longint unsigned act,
                        input longint unsigned exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic wrap_up();
      if (!finished) begin
         finished = 1;
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
         wrap_up();
      end
   end

   // Approximate quotient derived from R3 to R8.
   function automatic longint unsigned model(input longint unsigned a, input longint unsigned b);
      int pa = 0, pb = 0, s;
      longint unsigned na, nb, wa, wb, c, v;
      bit lost;
      if (b == 0) return QMAX;
      if (a == 0) return 0;
      for (int i = 0; i < DW; i++) if (a[i]) pa = i;
      for (int i = 0; i < N; i++)  if (b[i]) pb = i;
      na   = a << (DW - 1 - pa);
      nb   = b << (N - 1 - pb);
      wa   = na >> (DW - 2 * K);
      wb   = nb >> (N - K);
      lost = (na & ((64'd1 << (DW - 2 * K)) - 1)) != 0;
      c    = wa / wb;
      s    = pa - pb - K;
      if (s >= 0) begin
         v = c << s;
         if (lost && s > 0) v = v | ((64'd1 << s) - 1);
      end else begin
         v = c >> (-s);
      end
      return v & QMAX;
   endfunction

   task automatic apply(input longint unsigned a, input longint unsigned b,
                        input longint unsigned exp, input string tag);
      longint unsigned t;
      @(negedge clk);
      in_valid = 1'b1;
      dividend = DW'(a);
      divisor  = N'(b);
      @(negedge clk);
      check(out_valid == 1'b1, {"R1 valid ", tag}, out_valid, 1);
      check(quotient == DW'(exp), {"R3 quotient ", tag}, quotient, exp);
      check(div_by_zero == (b == 0), {"R7 flag ", tag}, div_by_zero, (b == 0));
      if (b != 0) begin
         t = a / b;
         check((2 * quotient + 2 >= t) && (quotient <= 2 * t + 1),
               {"R9 bound ", tag}, quotient, t);
      end
      // R10: new operands with in_valid low must not disturb the result.
      in_valid = 1'b0;
      dividend = DW'($urandom);
      divisor  = N'($urandom);
      @(negedge clk);
      check(out_valid == 1'b0, {"R1 idle ", tag}, out_valid, 0);
      check(quotient == DW'(exp), {"R10 hold ", tag}, quotient, exp);
   endtask

   initial begin
      longint unsigned a, b;
      void'($urandom(32'h5EED_0042));
      repeat (3) @(negedge clk);
      check(out_valid == 1'b0, "R2 valid", out_valid, 0);
      check(quotient == '0, "R2 quotient", quotient, 0);
      check(div_by_zero == 1'b0, "R2 flag", div_by_zero, 0);
      rst_n = 1'b1;

      apply(100,   7, 14,    "R3 100/7");
      apply(5,     3, 1,     "R4 zero fill 5/3");
      apply(1000,  3, 351,   "R5 or fill 1000/3");
      apply(65535, 1, 65535, "R5 max shift fill");
      apply(32768, 1, 32768, "R5 no dropped ones");
      apply(9,   200, 0,     "R6 right shift 9/200");
      apply(15,    8, 1,     "R6 right shift 15/8");
      apply(7,     0, QMAX,  "R7 zero divisor");
      apply(0,     0, QMAX,  "R7 both zero");
      apply(0,     5, 0,     "R8 zero dividend");

      for (int i = 0; i < 1500; i++) begin
         a = longint'($urandom) & ((64'd1 << ($urandom % (DW + 1))) - 1);
         b = longint'($urandom) & ((64'd1 << ($urandom % (N + 1))) - 1);
         apply(a, b, model(a, b), "R3 random");
      end

      // R2: reset clears a held result.
      rst_n = 1'b0;
      @(negedge clk);
      check(quotient == '0 && out_valid == 1'b0 && div_by_zero == 1'b0,
            "R2 reset again", quotient, 0);
      wrap_up();
   end

endmodule